// File: doc/BRIEF.md
# Two-Variant Interrupt Aggregator with Set/Clear Masking

This block gathers a word of peripheral interrupt lines into a single request for a parent interrupt controller. Each source owns one bit of a status word and one bit of a mask word. The parent request is raised whenever some source is pending and not masked. Software changes the mask only through two strobe registers: one that sets mask bits and one that clears them. A third view reads the mask back. This keeps read-modify-write sequences off the bus.

A build-time parameter picks one of two variants. In the latched variant, a rising edge on a source sets a sticky status bit. Software acknowledges the bit by writing a one to an acknowledge register. In the level variant, the status word is the live input level and there is no acknowledge register. The register layout differs between the two variants. All registers sit on a simple single-cycle port. Reads are combinational in the cycle they are issued, and writes take effect at the clock edge.

Top module: `irq_gather`

## Requirements
- R1: After reset every source is masked (mask view reads 0xFFFFFFFF), every latched status bit is 0 and `irq_out` is 0.
- R2: A write to the mask-set register (latched 0x10, level 0x08) sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged; writing all ones masks every source.
- R3: A write to the mask-clear register (latched 0x14, level 0x0C) clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged.
- R4: The mask view (latched 0x0C, level 0x04) reads the current mask, where bit n = 1 means source n is disabled.
- R5: In the latched variant, a 0-to-1 change of source n, as sampled at two consecutive clock edges, sets status bit n (read at 0x00). The bit stays set after the source falls, until it is acknowledged. Before the first edge after reset, the previous value of each source is taken as 0.
- R6: In the latched variant, writing to the acknowledge register (0x08) clears each status bit whose data bit is 1, and writing all ones clears them all. A rising edge on a bit in the same cycle as its acknowledge wins, so that bit stays set.
- R7: In the level variant, a read at 0x00 returns the live source levels in the same cycle, and no offset acknowledges anything.
- R8: Status bits capture (latched) or reflect (level) their sources whether or not they are masked. The mask affects only `irq_out`.
- R9: `irq_out` is a register. After each clock edge it equals the OR over all bits of (status AND NOT mask), taking the values that were present just before that edge.
- R10: `reg_rdata` is 0 when no read is issued (`reg_sel`=0 or `reg_wr`=1). Reads of the write-only set, clear and acknowledge registers return 0. Reads of any unmapped or unaligned offset return 0. Writes to unmapped offsets and to the status register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Peripheral interrupt lines, synchronous to `clk` |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when no read |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The assertions assume that `irq_src` and every register port are synchronous to `clk` and stable around its rising edge. They also assume that reset is asserted from time zero until after the first edge. The bench meets these assumptions by changing all inputs only at falling edges and by holding `rst_n` low for several cycles at the start. Corner cases are driven deliberately: a source that rises in the same cycle as its acknowledge, offsets that belong to the other variant, and unaligned offsets. A long random phase then mixes source toggles with arbitrary accesses to both variants.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_ACK,
        RK_MVIEW,
        RK_MSET,
        RK_MCLR
    } reg_kind_e;

    // latched variant layout
    localparam int OFFL_STAT  = 'h00;
    localparam int OFFL_ACK   = 'h08;
    localparam int OFFL_MVIEW = 'h0C;
    localparam int OFFL_MSET  = 'h10;
    localparam int OFFL_MCLR  = 'h14;

    // level variant layout
    localparam int OFFV_STAT  = 'h00;
    localparam int OFFV_MVIEW = 'h04;
    localparam int OFFV_MSET  = 'h08;
    localparam int OFFV_MCLR  = 'h0C;

endpackage

// File: rtl/irqg_decode.sv
module irqg_decode
    import irqg_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter bit LATCHED = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind
);

    generate
        if (LATCHED) begin : g_lat
            always_comb begin
                kind = RK_NONE;
                if (addr == ADDR_W'(OFFL_STAT))       kind = RK_STAT;
                else if (addr == ADDR_W'(OFFL_ACK))   kind = RK_ACK;
                else if (addr == ADDR_W'(OFFL_MVIEW)) kind = RK_MVIEW;
                else if (addr == ADDR_W'(OFFL_MSET))  kind = RK_MSET;
                else if (addr == ADDR_W'(OFFL_MCLR))  kind = RK_MCLR;
            end
        end else begin : g_lvl
            always_comb begin
                kind = RK_NONE;
                if (addr == ADDR_W'(OFFV_STAT))       kind = RK_STAT;
                else if (addr == ADDR_W'(OFFV_MVIEW)) kind = RK_MVIEW;
                else if (addr == ADDR_W'(OFFV_MSET))  kind = RK_MSET;
                else if (addr == ADDR_W'(OFFV_MCLR))  kind = RK_MCLR;
            end
        end
    endgenerate

endmodule

// File: rtl/irqg_mask.sv
module irqg_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (set_we) begin
            mask <= mask | bits;
        end else if (clr_we) begin
            mask <= mask & ~bits;
        end
    end

endmodule

// File: rtl/irqg_status.sv
module irqg_status #(
    parameter int W       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         ack_we,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] stat
);

    generate
        if (LATCHED) begin : g_lat
            logic [W-1:0] prev_q;
            logic [W-1:0] rise;
            logic [W-1:0] drop;

            assign rise = src & ~prev_q;
            assign drop = ack_we ? ack_bits : '0;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prev_q <= '0;
                    stat   <= '0;
                end else begin
                    prev_q <= src;
                    stat   <= (stat & ~drop) | rise;
                end
            end
        end else begin : g_lvl
            logic unused_lvl;
            assign unused_lvl = ^{clk, rst_n, ack_we, ack_bits};
            assign stat = src;
        end
    endgenerate

endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irqg_pkg::*;
#(
    parameter int SRC_W   = 32,
    parameter int ADDR_W  = 5,
    parameter bit LATCHED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  irq_src,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [SRC_W-1:0]  reg_wdata,
    output logic [SRC_W-1:0]  reg_rdata,
    output logic              irq_out
);

    reg_kind_e        kind;
    logic             wr_en;
    logic             rd_en;
    logic [SRC_W-1:0] stat_w;
    logic [SRC_W-1:0] mask_w;
    logic             irq_q;

    assign wr_en = reg_sel & reg_wr;
    assign rd_en = reg_sel & ~reg_wr;

    irqg_decode #(
        .ADDR_W  (ADDR_W),
        .LATCHED (LATCHED)
    ) u_dec (
        .addr (reg_addr),
        .kind (kind)
    );

    irqg_mask #(
        .W (SRC_W)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_en && (kind == RK_MSET)),
        .clr_we (wr_en && (kind == RK_MCLR)),
        .bits   (reg_wdata),
        .mask   (mask_w)
    );

    irqg_status #(
        .W       (SRC_W),
        .LATCHED (LATCHED)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .ack_we   (wr_en && (kind == RK_ACK)),
        .ack_bits (reg_wdata),
        .stat     (stat_w)
    );

    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            unique case (kind)
                RK_STAT:  reg_rdata = stat_w;
                RK_MVIEW: reg_rdata = mask_w;
                default:  reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_w & ~mask_w);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/irqg_chk.sv
module irqg_chk
    import irqg_pkg::*;
#(
    parameter int SRC_W   = 32,
    parameter int ADDR_W  = 5,
    parameter bit LATCHED = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  irq_src,
    input logic              reg_sel,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [SRC_W-1:0]  reg_wdata,
    input logic [SRC_W-1:0]  reg_rdata,
    input logic              irq_out,
    input logic [SRC_W-1:0]  stat,
    input logic [SRC_W-1:0]  mask
);

    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(LATCHED ? OFFL_MSET : OFFV_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(LATCHED ? OFFL_MCLR : OFFV_MCLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFFL_STAT);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFFL_ACK);

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask == '1 && !irq_out));

    a_r2_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == A_MSET)
        |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));

    a_r3_clear_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == A_MCLR)
        |=> ((mask & $past(reg_wdata)) == '0));

    a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |($past(stat) & ~$past(mask)));

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && !reg_wr) |-> (reg_rdata == '0));

    generate
        if (LATCHED) begin : g_lat
            a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                !(reg_sel && reg_wr && reg_addr == A_ACK)
                |=> (($past(stat) & ~stat) == '0));

            a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_sel && reg_wr && reg_addr == A_ACK)
                |=> ((stat & $past(reg_wdata & ~irq_src)) == '0));
        end else begin : g_lvl
            a_r7_live_status: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_sel && !reg_wr && reg_addr == A_STAT) |-> (reg_rdata == irq_src));
        end
    endgenerate

endmodule

bind irq_gather irqg_chk #(
    .SRC_W   (SRC_W),
    .ADDR_W  (ADDR_W),
    .LATCHED (LATCHED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .stat      (stat_w),
    .mask      (mask_w)
);

// File: tb/test_irq_gather.sv
module test_irq_gather;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;

    logic        e_sel = 1'b0, e_wr = 1'b0;
    logic [4:0]  e_addr = '0;
    logic [31:0] e_wd = '0, e_rdata;
    logic        e_irq;

    logic        l_sel = 1'b0, l_wr = 1'b0;
    logic [4:0]  l_addr = '0;
    logic [31:0] l_wd = '0, l_rdata;
    logic        l_irq;

    int n_chk = 0;
    int n_err = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_gather #(.LATCHED(1'b1)) i_irq_gather (
        .clk(clk), .rst_n(rst_n), .irq_src(src),
        .reg_sel(e_sel), .reg_wr(e_wr), .reg_addr(e_addr),
        .reg_wdata(e_wd), .reg_rdata(e_rdata), .irq_out(e_irq)
    );

    irq_gather #(.LATCHED(1'b0)) i_irq_gather_lvl (
        .clk(clk), .rst_n(rst_n), .irq_src(src),
        .reg_sel(l_sel), .reg_wr(l_wr), .reg_addr(l_addr),
        .reg_wdata(l_wd), .reg_rdata(l_rdata), .irq_out(l_irq)
    );

    // behavioural reference model
    logic [31:0] me_stat, me_mask, me_prev, ml_mask;
    logic        me_irq, ml_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            me_stat <= '0; me_mask <= '1; me_prev <= '0; me_irq <= 1'b0;
            ml_mask <= '1; ml_irq <= 1'b0;
        end else begin
            me_irq  <= (me_stat & ~me_mask) != 0;
            ml_irq  <= (src & ~ml_mask) != 0;
            me_prev <= src;
            if (e_sel && e_wr && e_addr == 5'h08)
                me_stat <= (me_stat & ~e_wd) | (src & ~me_prev);
            else
                me_stat <= me_stat | (src & ~me_prev);
            if (e_sel && e_wr && e_addr == 5'h10) me_mask <= me_mask | e_wd;
            if (e_sel && e_wr && e_addr == 5'h14) me_mask <= me_mask & ~e_wd;
            if (l_sel && l_wr && l_addr == 5'h08) ml_mask <= ml_mask | l_wd;
            if (l_sel && l_wr && l_addr == 5'h0C) ml_mask <= ml_mask & ~l_wd;
        end
    end

    function automatic logic [31:0] model_rd_e(input logic [4:0] a);
        case (a)
            5'h00:   return me_stat;
            5'h0C:   return me_mask;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] model_rd_l(input logic [4:0] a);
        case (a)
            5'h00:   return src;
            5'h04:   return ml_mask;
            default: return '0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && run_cmp) begin
            check({31'b0, e_irq}, {31'b0, me_irq}, "R9 latched irq_out");
            check({31'b0, l_irq}, {31'b0, ml_irq}, "R9 level irq_out");
            if (e_sel && !e_wr) check(e_rdata, model_rd_e(e_addr), "R4/R5/R10 latched read");
            else                check(e_rdata, 32'h0, "R10 latched idle rdata");
            if (l_sel && !l_wr) check(l_rdata, model_rd_l(l_addr), "R4/R7/R10 level read");
            else                check(l_rdata, 32'h0, "R10 level idle rdata");
        end
    end

    task automatic e_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); e_sel = 1'b1; e_wr = 1'b1; e_addr = a; e_wd = d;
        @(negedge clk); e_sel = 1'b0; e_wr = 1'b0;
    endtask

    task automatic l_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); l_sel = 1'b1; l_wr = 1'b1; l_addr = a; l_wd = d;
        @(negedge clk); l_sel = 1'b0; l_wr = 1'b0;
    endtask

    task automatic e_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); e_sel = 1'b1; e_wr = 1'b0; e_addr = a;
        #2 check(e_rdata, exp, tag);
        e_sel = 1'b0;
    endtask

    task automatic l_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); l_sel = 1'b1; l_wr = 1'b0; l_addr = a;
        #2 check(l_rdata, exp, tag);
        l_sel = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk); src = v;
    endtask

    task automatic irq_now(input logic ee, input logic el, input string tag);
        @(negedge clk);
        #2;
        check({31'b0, e_irq}, {31'b0, ee}, tag);
        check({31'b0, l_irq}, {31'b0, el}, tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1'b1;

        // R1 reset state
        e_read(5'h00, 32'h0, "R1 latched status after reset");
        e_read(5'h0C, 32'hFFFF_FFFF, "R1 latched mask after reset");
        l_read(5'h04, 32'hFFFF_FFFF, "R1 level mask after reset");
        irq_now(1'b0, 1'b0, "R1 irq_out after reset");

        // R5 one-cycle pulse latches; R7 level follows live input
        set_src(32'h5);
        set_src(32'h0);
        e_read(5'h00, 32'h5, "R5 pulse latched and held");
        l_read(5'h00, 32'h0, "R7 level status after pulse gone");
        set_src(32'h30);
        l_read(5'h00, 32'h30, "R7 level status live");
        e_read(5'h00, 32'h35, "R5 second edge latched");

        // R8 status captured while masked, no request
        irq_now(1'b0, 1'b0, "R8 masked sources keep irq_out low");

        // R3 / R4 unmask one source each
        e_write(5'h14, 32'h1);
        l_write(5'h0C, 32'h10);
        irq_now(1'b1, 1'b1, "R9 irq_out after unmask");
        e_read(5'h0C, 32'hFFFF_FFFE, "R3 R4 latched mask view");
        l_read(5'h04, 32'hFFFF_FFEF, "R3 R4 level mask view");

        // R2 re-mask
        e_write(5'h10, 32'h1);
        l_write(5'h08, 32'h10);
        e_read(5'h0C, 32'hFFFF_FFFF, "R2 latched mask set");
        l_read(5'h04, 32'hFFFF_FFFF, "R2 level mask set");
        irq_now(1'b0, 1'b0, "R9 irq_out after re-mask");

        // R6 acknowledge
        e_write(5'h08, 32'h4);
        e_read(5'h00, 32'h31, "R6 single acknowledge");
        e_write(5'h08, 32'hFFFF_FFFF);
        e_read(5'h00, 32'h0, "R6 acknowledge all");

        // R6 edge wins over same-cycle acknowledge
        @(negedge clk);
        src = 32'h34; e_sel = 1'b1; e_wr = 1'b1; e_addr = 5'h08; e_wd = 32'h4;
        @(negedge clk); e_sel = 1'b0; e_wr = 1'b0;
        e_read(5'h00, 32'h4, "R6 edge beats acknowledge");

        // R10 unmapped / status writes ignored, write-only reads zero
        e_write(5'h04, 32'hFFFF_FFFF);
        e_write(5'h18, 32'hFFFF_FFFF);
        e_write(5'h00, 32'h0);
        e_write(5'h15, 32'hFFFF_FFFF);
        e_read(5'h04, 32'h0, "R10 latched unmapped read");
        e_read(5'h0D, 32'h0, "R10 latched unaligned read");
        e_read(5'h08, 32'h0, "R10 latched acknowledge reads zero");
        e_read(5'h10, 32'h0, "R10 latched mask-set reads zero");
        e_read(5'h00, 32'h4, "R10 latched status untouched");
        e_read(5'h0C, 32'hFFFF_FFFF, "R10 latched mask untouched");
        l_write(5'h10, 32'hFFFF_FFFF);
        l_write(5'h14, 32'hFFFF_FFFF);
        l_write(5'h00, 32'h0);
        l_read(5'h04, 32'hFFFF_FFFF, "R10 level mask untouched");
        l_read(5'h14, 32'h0, "R10 level unmapped read");
        l_read(5'h0C, 32'h0, "R10 level mask-clear reads zero");
        l_read(5'h00, 32'h34, "R7 R10 level status still live");

        // random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) src = src ^ (32'h1 << ($urandom % 32)) ^ ($urandom & $urandom & $urandom);
            e_sel = $urandom % 2; e_wr = $urandom % 2;
            e_addr = (($urandom % 8) == 0) ? 5'($urandom) : 5'(($urandom % 6) * 4);
            e_wd = $urandom & $urandom;
            l_sel = $urandom % 2; l_wr = $urandom % 2;
            l_addr = (($urandom % 8) == 0) ? 5'($urandom) : 5'(($urandom % 6) * 4);
            l_wd = $urandom & $urandom;
        end
        @(negedge clk);
        e_sel = 1'b0; l_sel = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule